// File: doc/BRIEF.md
# External Function and Sense Sequencer

This block carries out the two I/O housekeeping commands of a channel-based processor: *select*, which places a device in a mode of operation, and *sense*, which asks a device whether a condition holds. A command arrives as a 15-bit operand holding five octal digits, plus a flag that picks select or sense and a flag that picks the input or output side. The top digit names one of seven channels. The low four digits form a 12-bit code. That code goes out on one set of function lines that every channel shares.

After a short lead time, the block raises exactly one of four ready strobes for the addressed channel: input function, output function, input sense or output sense. It then drops the strobe by itself after a fixed number of cycles. No acknowledgement from the device is involved. For a sense command, the device's response line passes through a synchroniser and is sampled when the strobe ends. The sampled value is reported as the condition bit, inverted when the low code bit is 1. A select whose code is zero is flagged as a channel clear for every device on that channel. While a command is in flight the block is busy, and it takes no new command.

Top module: `xfs_seq`

## Requirements
- R1: While reset is high and after it is released, `busy`, `fn_code`, all strobe and clear vectors, `sense_valid` and `sense_cond` are zero.
- R2: A command is accepted on a clock edge where `cmd_valid` is 1, `busy` is 0 and operand bits [14:12] (the channel, 1 to 7) are nonzero. From the next cycle on, `fn_code` equals operand bits [11:0] and holds that value until the next accepted command.
- R3: The flags choose the strobe vector as follows: sense=0,output=0 gives `in_fn_rdy`; sense=0,output=1 gives `out_fn_rdy`; sense=1,output=0 gives `in_sn_rdy`; sense=1,output=1 gives `out_sn_rdy`. Bit (channel-1) of that vector is the only strobe bit raised.
- R4: For a command accepted at edge k, the strobe is high in the cycles after edges k+LEAD_CYC through k+LEAD_CYC+STROBE_CYC-1. In the first LEAD_CYC cycles of `busy`, no strobe is high.
- R5: `busy` is high in the cycles after edges k through k+LEAD_CYC+STROBE_CYC-1. The strobe and `busy` both fall without any input from the device.
- R6: A command presented while `busy` is 1 is ignored. So is a command to channel 0. Neither changes `fn_code`, `busy` or any strobe.
- R7: At the edge that ends a sense strobe, `sense_cond` is loaded with the synchronised response XOR code bit 0, and `sense_valid` is 1 for exactly the following cycle. The response is synchronised through two flops, so it must be stable for two cycles before that edge.
- R8: A select command never raises `sense_valid` and leaves `sense_cond` unchanged.
- R9: A select with code 0 raises `clr_chan[channel-1]` for exactly the cycles of its function strobe. A sense with code 0, or any nonzero code, raises no clear bit.
- R10: A command held on `cmd_valid` through the edge where the strobe ends is not taken at that edge. It is accepted one edge later, which leaves exactly one idle cycle between two back-to-back commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_operand | input | 15 | [14:12] channel, [11:0] function code |
| cmd_sense | input | 1 | 1 = sense, 0 = select |
| cmd_output | input | 1 | 1 = output side, 0 = input side |
| resp_in | input | 1 | Asynchronous sense response from equipment |
| busy | output | 1 | Command in flight, new commands ignored |
| fn_code | output | 12 | Code broadcast on the shared function lines |
| in_fn_rdy | output | 7 | Input function ready, one bit per channel 1..7 |
| out_fn_rdy | output | 7 | Output function ready, per channel |
| in_sn_rdy | output | 7 | Input sense ready, per channel |
| out_sn_rdy | output | 7 | Output sense ready, per channel |
| clr_chan | output | 7 | Channel clear indication, per channel |
| sense_valid | output | 1 | One-cycle pulse, condition bit updated |
| sense_cond | output | 1 | Reported sense condition |

## Verification
Two things can fall in one cycle. A sense strobe can end and sample its response on the same edge where a new command is already waiting. A held request must lose that edge and win the next one, and the sampled condition must still belong to the old command. The bench provokes this by holding `cmd_valid` high across a whole command and by issuing random back-to-back requests while the response line toggles. A behavioural countdown model, with its own two-stage copy of the response, predicts busy, every strobe bit, the clear bits and the sense result on every cycle. The bench compares the design against that model on every cycle.

// File: rtl/xfs_pkg.sv
package xfs_pkg;

    localparam int CHAN_W = 3;
    localparam int CODE_W = 12;
    localparam int NCHAN  = (1 << CHAN_W) - 1;
    localparam int OPND_W = CHAN_W + CODE_W;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic [CODE_W-1:0] code;
        logic              sense;
        logic              outdir;
    } xfs_cmd_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LEAD   = 2'd1,
        PH_STROBE = 2'd2
    } xfs_phase_e;

    // strobe kind: bit1 = sense, bit0 = output side
    typedef enum logic [1:0] {
        K_IN_FN  = 2'd0,
        K_OUT_FN = 2'd1,
        K_IN_SN  = 2'd2,
        K_OUT_SN = 2'd3
    } xfs_kind_e;

    function automatic xfs_kind_e kind_of(input logic sense, input logic outdir);
        return xfs_kind_e'({sense, outdir});
    endfunction

    function automatic logic is_clear_code(input logic [CODE_W-1:0] code);
        return code == '0;
    endfunction

endpackage

// File: rtl/xfs_timer.sv
module xfs_timer
    import xfs_pkg::*;
#(
    parameter int LEAD_CYC   = 3,
    parameter int STROBE_CYC = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output xfs_phase_e phase,
    output logic       last
);
    localparam int MAXC  = (LEAD_CYC > STROBE_CYC) ? LEAD_CYC : STROBE_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);

    logic [CNT_W-1:0] cnt;

    assign last = (phase == PH_STROBE) && (cnt == CNT_W'(STROBE_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_LEAD;
                        cnt   <= '0;
                    end
                end
                PH_LEAD: begin
                    if (cnt == CNT_W'(LEAD_CYC - 1)) begin
                        phase <= PH_STROBE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (last) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/xfs_sync.sv
module xfs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/xfs_strobe_dec.sv
module xfs_strobe_dec
    import xfs_pkg::*;
(
    input  logic             active,
    input  xfs_cmd_t         cmd,
    output logic [NCHAN-1:0] in_fn,
    output logic [NCHAN-1:0] out_fn,
    output logic [NCHAN-1:0] in_sn,
    output logic [NCHAN-1:0] out_sn,
    output logic [NCHAN-1:0] clr
);
    xfs_kind_e kind;
    logic      clear_cmd;

    assign kind      = kind_of(cmd.sense, cmd.outdir);
    assign clear_cmd = !cmd.sense && is_clear_code(cmd.code);

    for (genvar ch = 0; ch < NCHAN; ch++) begin : g_ch
        logic hit;
        assign hit        = active && (cmd.chan == CHAN_W'(ch + 1));
        assign in_fn[ch]  = hit && (kind == K_IN_FN);
        assign out_fn[ch] = hit && (kind == K_OUT_FN);
        assign in_sn[ch]  = hit && (kind == K_IN_SN);
        assign out_sn[ch] = hit && (kind == K_OUT_SN);
        assign clr[ch]    = hit && clear_cmd;
    end
endmodule

// File: rtl/xfs_seq.sv
module xfs_seq
    import xfs_pkg::*;
#(
    parameter int LEAD_CYC   = 3,
    parameter int STROBE_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [OPND_W-1:0] cmd_operand,
    input  logic              cmd_sense,
    input  logic              cmd_output,
    input  logic              resp_in,
    output logic              busy,
    output logic [CODE_W-1:0] fn_code,
    output logic [NCHAN-1:0]  in_fn_rdy,
    output logic [NCHAN-1:0]  out_fn_rdy,
    output logic [NCHAN-1:0]  in_sn_rdy,
    output logic [NCHAN-1:0]  out_sn_rdy,
    output logic [NCHAN-1:0]  clr_chan,
    output logic              sense_valid,
    output logic              sense_cond
);
    xfs_phase_e phase;
    logic       last;
    logic       accept;
    logic       resp_s;
    xfs_cmd_t   cmd_q;

    assign busy   = (phase != PH_IDLE);
    assign accept = cmd_valid && !busy && (cmd_operand[OPND_W-1 -: CHAN_W] != '0);

    xfs_timer #(
        .LEAD_CYC  (LEAD_CYC),
        .STROBE_CYC(STROBE_CYC)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .start(accept),
        .phase(phase),
        .last (last)
    );

    xfs_sync #(.STAGES(2)) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (resp_in),
        .q  (resp_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (accept) begin
            cmd_q.chan   <= cmd_operand[OPND_W-1 -: CHAN_W];
            cmd_q.code   <= cmd_operand[CODE_W-1:0];
            cmd_q.sense  <= cmd_sense;
            cmd_q.outdir <= cmd_output;
        end
    end

    assign fn_code = cmd_q.code;

    xfs_strobe_dec u_dec (
        .active(phase == PH_STROBE),
        .cmd   (cmd_q),
        .in_fn (in_fn_rdy),
        .out_fn(out_fn_rdy),
        .in_sn (in_sn_rdy),
        .out_sn(out_sn_rdy),
        .clr   (clr_chan)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sense_valid <= 1'b0;
            sense_cond  <= 1'b0;
        end else begin
            sense_valid <= last && cmd_q.sense;
            if (last && cmd_q.sense)
                sense_cond <= resp_s ^ cmd_q.code[0];
        end
    end
endmodule

// File: rtl/xfs_seq_chk.sv
module xfs_seq_chk
    import xfs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [OPND_W-1:0] cmd_operand,
    input logic              busy,
    input logic [CODE_W-1:0] fn_code,
    input logic [NCHAN-1:0]  in_fn_rdy,
    input logic [NCHAN-1:0]  out_fn_rdy,
    input logic [NCHAN-1:0]  in_sn_rdy,
    input logic [NCHAN-1:0]  out_sn_rdy,
    input logic [NCHAN-1:0]  clr_chan,
    input logic              sense_valid
);
    logic any_stb, any_sn;
    assign any_stb = |{in_fn_rdy, out_fn_rdy, in_sn_rdy, out_sn_rdy};
    assign any_sn  = |{in_sn_rdy, out_sn_rdy};

    a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({in_fn_rdy, out_fn_rdy, in_sn_rdy, out_sn_rdy}));

    a_r5_strobe_within_busy: assert property (@(posedge clk) disable iff (rst)
        any_stb |-> busy);

    a_r2_accept_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && cmd_operand[OPND_W-1 -: CHAN_W] != '0) |=> busy);

    a_r6_code_held_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(fn_code));

    a_r4_no_strobe_at_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !any_stb);

    a_r7_sense_after_strobe: assert property (@(posedge clk) disable iff (rst)
        sense_valid |-> ($past(any_sn) && !any_sn));

    a_r9_clear_with_select: assert property (@(posedge clk) disable iff (rst)
        (|clr_chan) |-> (((clr_chan & (in_fn_rdy | out_fn_rdy)) == clr_chan) && fn_code == '0));
endmodule

bind xfs_seq xfs_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_operand(cmd_operand),
    .busy       (busy),
    .fn_code    (fn_code),
    .in_fn_rdy  (in_fn_rdy),
    .out_fn_rdy (out_fn_rdy),
    .in_sn_rdy  (in_sn_rdy),
    .out_sn_rdy (out_sn_rdy),
    .clr_chan   (clr_chan),
    .sense_valid(sense_valid)
);

// File: tb/xfs_seq_tb.sv
module xfs_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LEAD = 3;
    localparam int STB  = 16;
    localparam int TOT  = LEAD + STB;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [14:0] cmd_operand = '0;
    logic        cmd_sense = 1'b0;
    logic        cmd_output = 1'b0;
    logic        resp_in = 1'b0;
    logic        busy;
    logic [11:0] fn_code;
    logic [6:0]  in_fn_rdy, out_fn_rdy, in_sn_rdy, out_sn_rdy, clr_chan;
    logic        sense_valid, sense_cond;

    xfs_seq #(.LEAD_CYC(LEAD), .STROBE_CYC(STB)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_operand(cmd_operand),
        .cmd_sense(cmd_sense), .cmd_output(cmd_output), .resp_in(resp_in),
        .busy(busy), .fn_code(fn_code), .in_fn_rdy(in_fn_rdy), .out_fn_rdy(out_fn_rdy),
        .in_sn_rdy(in_sn_rdy), .out_sn_rdy(out_sn_rdy), .clr_chan(clr_chan),
        .sense_valid(sense_valid), .sense_cond(sense_cond)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: countdown of remaining busy cycles
    int       rem = 0;
    int       m_chan = 0;
    bit [11:0] m_code = '0;
    bit       m_sense = 0, m_out = 0;
    bit       m_sv = 0, m_sc = 0, r1 = 0, r2 = 0;

    always @(posedge clk) begin
        if (rst) begin
            rem = 0; m_chan = 0; m_code = '0; m_sense = 0; m_out = 0;
            m_sv = 0; m_sc = 0; r1 = 0; r2 = 0;
        end else begin
            if (rem == 1 && m_sense) begin
                m_sc = r2 ^ m_code[0];
                m_sv = 1;
            end else begin
                m_sv = 0;
            end
            r2 = r1;
            r1 = resp_in;
            if (rem > 0) rem = rem - 1;
            else if (cmd_valid && cmd_operand[14:12] != 0) begin
                m_chan  = int'(cmd_operand[14:12]);
                m_code  = cmd_operand[11:0];
                m_sense = cmd_sense;
                m_out   = cmd_output;
                rem     = TOT;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            logic [6:0] e_if, e_of, e_is, e_os, e_cl;
            e_if = '0; e_of = '0; e_is = '0; e_os = '0; e_cl = '0;
            if (rem > 0 && rem <= STB) begin
                case ({m_sense, m_out})
                    2'b00: e_if[m_chan-1] = 1'b1;
                    2'b01: e_of[m_chan-1] = 1'b1;
                    2'b10: e_is[m_chan-1] = 1'b1;
                    default: e_os[m_chan-1] = 1'b1;
                endcase
                if (!m_sense && m_code == 0) e_cl[m_chan-1] = 1'b1;
            end
            chk(busy == (rem > 0), "R5 busy", busy, rem > 0);
            chk(fn_code == m_code, "R2 fn_code", fn_code, m_code);
            chk({in_fn_rdy, out_fn_rdy, in_sn_rdy, out_sn_rdy} == {e_if, e_of, e_is, e_os},
                "R3 R4 strobes", {in_fn_rdy, out_fn_rdy, in_sn_rdy, out_sn_rdy},
                {e_if, e_of, e_is, e_os});
            chk(clr_chan == e_cl, "R9 clr_chan", clr_chan, e_cl);
            chk(sense_valid == m_sv, "R7 sense_valid", sense_valid, m_sv);
            chk(sense_cond == m_sc, "R7 R8 sense_cond", sense_cond, m_sc);
        end
    end

    task automatic issue(input int ch, input int code, input bit sn, input bit od);
        @(negedge clk);
        cmd_valid   = 1'b1;
        cmd_operand = {3'(ch), 12'(code)};
        cmd_sense   = sn;
        cmd_output  = od;
        @(negedge clk);
        cmd_valid   = 1'b0;
    endtask

    task automatic settle();
        repeat (TOT + 2) @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk({busy, fn_code, in_fn_rdy, out_fn_rdy, in_sn_rdy, out_sn_rdy, clr_chan,
             sense_valid, sense_cond} == '0, "R1 reset", fn_code, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && fn_code == 0 && !sense_cond, "R1 after release", busy, 0);

        // R2 R3: all four kinds on different channels
        issue(1, 'o1234, 0, 0);
        chk(fn_code == 12'o1234, "R2 code latched", fn_code, 12'o1234);
        settle();
        issue(7, 'o7777, 0, 1); settle();
        issue(3, 'o0042, 1, 0); settle();
        issue(5, 'o5550, 1, 1); settle();

        // R7: sense polarity
        resp_in = 1'b1;
        issue(2, 'o0010, 1, 0); settle();
        chk(sense_cond == 1'b1, "R7 resp1 bit0=0", sense_cond, 1);
        issue(2, 'o0011, 1, 1); settle();
        chk(sense_cond == 1'b0, "R7 resp1 bit0=1", sense_cond, 0);
        resp_in = 1'b0;
        issue(6, 'o0013, 1, 0); settle();
        chk(sense_cond == 1'b1, "R7 resp0 bit0=1", sense_cond, 1);

        // R8: select leaves sense_cond alone
        issue(4, 'o0100, 0, 0); settle();
        chk(sense_cond == 1'b1, "R8 select keeps cond", sense_cond, 1);

        // R9: clear code on select vs sense
        issue(4, 0, 0, 1);
        repeat (LEAD) @(negedge clk);
        chk(clr_chan == 7'b0001000, "R9 select clear", clr_chan, 7'b0001000);
        settle();
        issue(4, 0, 1, 0);
        repeat (LEAD) @(negedge clk);
        chk(clr_chan == '0 && in_sn_rdy == 7'b0001000, "R9 sense no clear", clr_chan, 0);
        settle();

        // R6: command while busy, and channel 0
        issue(3, 'o0555, 0, 0);
        issue(6, 'o0777, 1, 1);
        chk(fn_code == 12'o0555, "R6 busy ignore", fn_code, 12'o0555);
        settle();
        issue(0, 'o0666, 0, 0);
        chk(!busy && fn_code == 12'o0555, "R6 channel 0", fn_code, 12'o0555);

        // R10: held request across strobe end
        begin
            int hi;
            hi = 0;
            @(negedge clk);
            cmd_valid = 1'b1; cmd_operand = {3'd2, 12'o0321}; cmd_sense = 1; cmd_output = 0;
            @(negedge clk);
            while (busy && hi < 100) begin hi++; @(negedge clk); end
            chk(hi == TOT, "R10 busy length", hi, TOT);
            chk(!busy, "R10 idle gap", busy, 0);
            @(negedge clk);
            chk(busy, "R10 reaccept", busy, 1);
            cmd_valid = 1'b0;
            settle();
        end

        // random stress against the model
        for (int i = 0; i < 1500; i++) begin
            @(negedge clk);
            cmd_valid   = ($urandom % 4) == 0;
            cmd_operand = 15'($urandom);
            if (($urandom % 8) == 0) cmd_operand[11:0] = '0;
            cmd_sense   = 1'($urandom);
            cmd_output  = 1'($urandom);
            if (($urandom % 5) == 0) resp_in = ~resp_in;
        end
        cmd_valid = 1'b0;
        settle();

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end
endmodule